// File: doc/BRIEF.md
# Serial NAND Operation Sequencer

This block takes whole-array requests (read a page, program a page, erase a block) and breaks each one into the series of command frames that a serial NAND device expects. A frame engine below it shifts the frames out on the serial bus. The sequencer sends one frame descriptor at a time: an opcode, an address with its byte count, a dummy-byte count, a data direction and a data length. It waits for the engine to report that the frame has finished before it moves to the next step.

After every array operation the sequencer reads the status register again and again until the device stops reporting busy. It gives up after a set number of polls. It then decodes the final status byte into a single result code. A read also transfers the page out of the device cache before the result is given. Program and erase each start with a write-enable frame.

The result is a one-cycle pulse that carries the result code and the status byte it was taken from. The request port accepts a new operation in the cycle after that pulse.

Top module: `nand_op_seq`

## Requirements
- R1: After reset, `req_ready` is 1, and `frm_valid` and `res_valid` are both 0.
- R2: A request is taken only when `req_valid` and `req_ready` are both high. After that, `req_ready` stays 0 until the result cycle has passed. Requests made during that time have no effect. The op code 3 is reserved: it starts nothing and `req_ready` stays 1. The op codes are 0 = page read, 1 = page program, 2 = block erase.
- R3: Only one frame is outstanding at a time. `frm_valid` and all descriptor fields stay unchanged until the cycle in which `frm_done` is high.
- R4: A page read issues the frames in this order:
  - opcode 0x13 with the row address and 3 address bytes, no data;
  - status polls;
  - opcode 0x03 with the column address, 2 address bytes, 1 dummy byte, data direction in (1) and length PAGE_BYTES.
- R5: A page program issues the frames in this order:
  - 0x06 with no address and no data;
  - 0x02 with the column address, 2 address bytes, direction out (2) and length PAGE_BYTES;
  - 0x10 with the row address and 3 address bytes;
  - status polls.
- R6: A block erase issues the frames in this order:
  - 0x06;
  - 0xD8 with the row address and 3 address bytes;
  - status polls.
- R7: A status poll is opcode 0x0F with address 0xC0, 1 address byte, direction in and length 1. It is sent again for as long as bit 0 (busy) of the byte returned on `frm_rdata` is 1.
- R8: If MAX_POLLS poll replies in a row all show busy, the result is TIMEOUT (code 5). No further frame is issued, and for a read this includes the cache read.
- R9: For a read, status bits 5:4 give the result:
  - 00 gives PASS (0);
  - 01 gives ECC_FIXED (1);
  - 10 and 11 both give ECC_LOST (2).
- R10: The fail bits are judged only from a status byte with the busy bit clear.
  - For a program, bit 3 set gives PROG_FAIL (3), otherwise the result is PASS.
  - For an erase, bit 2 set gives ERASE_FAIL (4), otherwise the result is PASS.
  - Status bits that do not belong to the operation are ignored.
- R11: `res_valid` pulses for exactly one cycle, the cycle after the last frame's `frm_done`. It carries `res_code` and `res_status`, the last status byte that was polled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, able to take a request |
| req_op | input | 2 | 0 read, 1 program, 2 erase, 3 reserved |
| req_row | input | ROW_W | Page or block row address |
| req_col | input | COL_W | Byte column inside the page |
| frm_valid | output | 1 | Frame descriptor valid, held until done |
| frm_done | input | 1 | Frame engine finished the current frame |
| frm_rdata | input | 8 | First byte read by the finished frame |
| frm_opcode | output | 8 | Command opcode |
| frm_addr | output | 24 | Address value, right-aligned |
| frm_naddr | output | 2 | Number of address bytes (0..3) |
| frm_ndummy | output | 2 | Number of dummy bytes |
| frm_dir | output | 2 | 0 no data, 1 data in, 2 data out |
| frm_len | output | clog2(PAGE_BYTES+1) | Data byte count |
| res_valid | output | 1 | Result pulse |
| res_code | output | 3 | 0 pass, 1 ECC fixed, 2 ECC lost, 3 program fail, 4 erase fail, 5 timeout |
| res_status | output | 8 | Status byte the result was taken from |

## Verification
The assertions check the following on every cycle:
- a descriptor is held until it is done, and `req_ready` is low while a frame is out;
- the result is a single pulse that follows a frame completion;
- a timeout is reported only with a busy status byte, and every other verdict only with the busy bit clear;
- every poll frame targets the status register.

The order of frames for each operation, the address placed in each frame, the ECC and fail decoding, the poll limit and the effect of ignored requests depend on what the frame engine replies. Only the bench's scenarios can show these, by checking every descriptor against its own model of each operation.

// File: rtl/nseq_pkg.sv
package nseq_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2,
        OP_NONE  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        DIR_NONE = 2'd0,
        DIR_IN   = 2'd1,
        DIR_OUT  = 2'd2
    } dir_e;

    typedef enum logic [2:0] {
        RES_PASS       = 3'd0,
        RES_ECC_FIXED  = 3'd1,
        RES_ECC_LOST   = 3'd2,
        RES_PROG_FAIL  = 3'd3,
        RES_ERASE_FAIL = 3'd4,
        RES_TIMEOUT    = 3'd5
    } res_e;

    typedef enum logic [2:0] {
        STEP_WREN,
        STEP_LOAD,
        STEP_EXEC,
        STEP_ARRAY_RD,
        STEP_ERASE,
        STEP_POLL,
        STEP_CACHE_RD
    } step_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_FRAME,
        PH_REPORT
    } phase_e;

    typedef struct packed {
        logic [7:0]  opcode;
        logic [23:0] addr;
        logic [1:0]  naddr;
        logic [1:0]  ndummy;
        dir_e        dir;
    } frame_desc_t;

    // Command opcodes
    localparam logic [7:0] OPC_WREN      = 8'h06;
    localparam logic [7:0] OPC_LOAD      = 8'h02;
    localparam logic [7:0] OPC_EXEC      = 8'h10;
    localparam logic [7:0] OPC_ARRAY_RD  = 8'h13;
    localparam logic [7:0] OPC_CACHE_RD  = 8'h03;
    localparam logic [7:0] OPC_ERASE     = 8'hD8;
    localparam logic [7:0] OPC_GET_FEAT  = 8'h0F;
    localparam logic [7:0] STATUS_REG    = 8'hC0;

    // Status byte fields
    localparam int BIT_BUSY       = 0;
    localparam int BIT_ERASE_FAIL = 2;
    localparam int BIT_PROG_FAIL  = 3;
    localparam int ECC_LSB        = 4;

    function automatic step_e first_step(op_e op);
        return (op == OP_READ) ? STEP_ARRAY_RD : STEP_WREN;
    endfunction

    function automatic res_e ecc_verdict(logic [1:0] ecc);
        case (ecc)
            2'b00:   return RES_PASS;
            2'b01:   return RES_ECC_FIXED;
            default: return RES_ECC_LOST;
        endcase
    endfunction

endpackage

// File: rtl/nseq_frame_fmt.sv
module nseq_frame_fmt
    import nseq_pkg::*;
#(
    parameter int ROW_W       = 24,
    parameter int COL_W       = 16,
    parameter int PAGE_BYTES  = 2112,
    parameter int CACHE_DUMMY = 1,
    localparam int LEN_W      = $clog2(PAGE_BYTES + 1)
) (
    input  step_e              step,
    input  logic [ROW_W-1:0]   row,
    input  logic [COL_W-1:0]   col,
    output frame_desc_t        desc,
    output logic [LEN_W-1:0]   len
);

    localparam logic [LEN_W-1:0] PAGE_LEN = LEN_W'(PAGE_BYTES);

    always_comb begin
        desc.opcode = OPC_WREN;
        desc.addr   = '0;
        desc.naddr  = 2'd0;
        desc.ndummy = 2'd0;
        desc.dir    = DIR_NONE;
        len         = '0;
        case (step)
            STEP_WREN: begin
                desc.opcode = OPC_WREN;
            end
            STEP_LOAD: begin
                desc.opcode = OPC_LOAD;
                desc.addr   = 24'(col);
                desc.naddr  = 2'd2;
                desc.dir    = DIR_OUT;
                len         = PAGE_LEN;
            end
            STEP_EXEC: begin
                desc.opcode = OPC_EXEC;
                desc.addr   = 24'(row);
                desc.naddr  = 2'd3;
            end
            STEP_ARRAY_RD: begin
                desc.opcode = OPC_ARRAY_RD;
                desc.addr   = 24'(row);
                desc.naddr  = 2'd3;
            end
            STEP_ERASE: begin
                desc.opcode = OPC_ERASE;
                desc.addr   = 24'(row);
                desc.naddr  = 2'd3;
            end
            STEP_POLL: begin
                desc.opcode = OPC_GET_FEAT;
                desc.addr   = 24'(STATUS_REG);
                desc.naddr  = 2'd1;
                desc.dir    = DIR_IN;
                len         = LEN_W'(1);
            end
            STEP_CACHE_RD: begin
                desc.opcode = OPC_CACHE_RD;
                desc.addr   = 24'(col);
                desc.naddr  = 2'd2;
                desc.ndummy = 2'(CACHE_DUMMY);
                desc.dir    = DIR_IN;
                len         = PAGE_LEN;
            end
            default: begin
                desc.opcode = OPC_WREN;
            end
        endcase
    end

endmodule

// File: rtl/nseq_status_eval.sv
module nseq_status_eval
    import nseq_pkg::*;
(
    input  op_e        op,
    input  logic [7:0] status,
    output logic       busy,
    output res_e       verdict
);

    logic unused_status_bits;
    assign unused_status_bits = ^{status[7:6], status[1]};

    assign busy = status[BIT_BUSY];

    always_comb begin
        case (op)
            OP_READ:  verdict = ecc_verdict(status[ECC_LSB +: 2]);
            OP_PROG:  verdict = status[BIT_PROG_FAIL]  ? RES_PROG_FAIL  : RES_PASS;
            OP_ERASE: verdict = status[BIT_ERASE_FAIL] ? RES_ERASE_FAIL : RES_PASS;
            default:  verdict = RES_PASS;
        endcase
    end

endmodule

// File: rtl/nseq_poll_ctr.sv
module nseq_poll_ctr #(
    parameter int MAX_POLLS = 4096,
    localparam int CW       = $clog2(MAX_POLLS + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic bump,
    output logic last
);

    logic [CW-1:0] cnt;

    assign last = (cnt == CW'(MAX_POLLS - 1));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (bump && !last) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/nand_op_seq.sv
module nand_op_seq
    import nseq_pkg::*;
#(
    parameter int ROW_W       = 24,
    parameter int COL_W       = 16,
    parameter int PAGE_BYTES  = 2112,
    parameter int MAX_POLLS   = 4096,
    parameter int CACHE_DUMMY = 1
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              req_valid,
    output logic                              req_ready,
    input  logic [1:0]                        req_op,
    input  logic [ROW_W-1:0]                  req_row,
    input  logic [COL_W-1:0]                  req_col,
    output logic                              frm_valid,
    input  logic                              frm_done,
    input  logic [7:0]                        frm_rdata,
    output logic [7:0]                        frm_opcode,
    output logic [23:0]                       frm_addr,
    output logic [1:0]                        frm_naddr,
    output logic [1:0]                        frm_ndummy,
    output logic [1:0]                        frm_dir,
    output logic [$clog2(PAGE_BYTES+1)-1:0]   frm_len,
    output logic                              res_valid,
    output logic [2:0]                        res_code,
    output logic [7:0]                        res_status
);

    localparam int LEN_W = $clog2(PAGE_BYTES + 1);

    phase_e             phase;
    step_e              step;
    op_e                op_q;
    logic [ROW_W-1:0]   row_q;
    logic [COL_W-1:0]   col_q;
    logic [7:0]         status_q;
    res_e               code_q;

    frame_desc_t        desc;
    logic [LEN_W-1:0]   desc_len;
    logic               st_busy;
    res_e               st_verdict;
    logic               poll_last;
    logic               frame_end;
    logic               poll_end;

    nseq_frame_fmt #(
        .ROW_W       (ROW_W),
        .COL_W       (COL_W),
        .PAGE_BYTES  (PAGE_BYTES),
        .CACHE_DUMMY (CACHE_DUMMY)
    ) u_fmt (
        .step (step),
        .row  (row_q),
        .col  (col_q),
        .desc (desc),
        .len  (desc_len)
    );

    nseq_status_eval u_eval (
        .op      (op_q),
        .status  (frm_rdata),
        .busy    (st_busy),
        .verdict (st_verdict)
    );

    assign frame_end = (phase == PH_FRAME) && frm_done;
    assign poll_end  = frame_end && (step == STEP_POLL);

    nseq_poll_ctr #(
        .MAX_POLLS (MAX_POLLS)
    ) u_polls (
        .clk   (clk),
        .rst   (rst),
        .clear (phase == PH_IDLE),
        .bump  (poll_end && st_busy),
        .last  (poll_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            step     <= STEP_WREN;
            op_q     <= OP_READ;
            row_q    <= '0;
            col_q    <= '0;
            status_q <= '0;
            code_q   <= RES_PASS;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (req_valid && (op_e'(req_op) != OP_NONE)) begin
                        op_q  <= op_e'(req_op);
                        row_q <= req_row;
                        col_q <= req_col;
                        step  <= first_step(op_e'(req_op));
                        phase <= PH_FRAME;
                    end
                end
                PH_FRAME: begin
                    if (frm_done) begin
                        case (step)
                            STEP_WREN:
                                step <= (op_q == OP_PROG) ? STEP_LOAD : STEP_ERASE;
                            STEP_LOAD:
                                step <= STEP_EXEC;
                            STEP_EXEC, STEP_ARRAY_RD, STEP_ERASE:
                                step <= STEP_POLL;
                            STEP_POLL: begin
                                status_q <= frm_rdata;
                                if (st_busy) begin
                                    if (poll_last) begin
                                        code_q <= RES_TIMEOUT;
                                        phase  <= PH_REPORT;
                                    end
                                end else begin
                                    code_q <= st_verdict;
                                    if (op_q == OP_READ) begin
                                        step <= STEP_CACHE_RD;
                                    end else begin
                                        phase <= PH_REPORT;
                                    end
                                end
                            end
                            default:
                                phase <= PH_REPORT;
                        endcase
                    end
                end
                default: begin
                    phase <= PH_IDLE;
                end
            endcase
        end
    end

    assign req_ready  = (phase == PH_IDLE);
    assign frm_valid  = (phase == PH_FRAME);
    assign frm_opcode = desc.opcode;
    assign frm_addr   = desc.addr;
    assign frm_naddr  = desc.naddr;
    assign frm_ndummy = desc.ndummy;
    assign frm_dir    = desc.dir;
    assign frm_len    = desc_len;
    assign res_valid  = (phase == PH_REPORT);
    assign res_code   = code_q;
    assign res_status = status_q;

endmodule

// File: rtl/nseq_checker.sv
module nseq_checker (
    input logic        clk,
    input logic        rst,
    input logic        req_ready,
    input logic        frm_valid,
    input logic        frm_done,
    input logic [7:0]  frm_opcode,
    input logic [23:0] frm_addr,
    input logic [1:0]  frm_naddr,
    input logic [1:0]  frm_ndummy,
    input logic [1:0]  frm_dir,
    input logic        res_valid,
    input logic [2:0]  res_code,
    input logic [7:0]  res_status
);

    AST_FRAME_HELD: assert property (@(posedge clk) disable iff (rst)
        frm_valid && !frm_done |=> frm_valid && $stable(frm_opcode) && $stable(frm_addr)
            && $stable(frm_naddr) && $stable(frm_ndummy) && $stable(frm_dir)); // R3

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        frm_valid |-> !req_ready); // R2

    AST_RESULT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid && req_ready); // R11

    AST_RESULT_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(frm_done) && $past(frm_valid)); // R11

    AST_TIMEOUT_BUSY: assert property (@(posedge clk) disable iff (rst)
        res_valid && res_code == 3'd5 |-> res_status[0]); // R8

    AST_VERDICT_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        res_valid && res_code != 3'd5 |-> !res_status[0]); // R10

    AST_POLL_TARGET: assert property (@(posedge clk) disable iff (rst)
        frm_valid && frm_opcode == 8'h0F |-> frm_addr == 24'h0000C0 && frm_naddr == 2'd1
            && frm_dir == 2'd1); // R7

endmodule

bind nand_op_seq nseq_checker u_nseq_checker (
    .clk        (clk),
    .rst        (rst),
    .req_ready  (req_ready),
    .frm_valid  (frm_valid),
    .frm_done   (frm_done),
    .frm_opcode (frm_opcode),
    .frm_addr   (frm_addr),
    .frm_naddr  (frm_naddr),
    .frm_ndummy (frm_ndummy),
    .frm_dir    (frm_dir),
    .res_valid  (res_valid),
    .res_code   (res_code),
    .res_status (res_status)
);

// File: tb/nand_op_seq_test.sv
`timescale 1ns/1ps
module nand_op_seq_test;

    localparam int PB = 16;
    localparam int MP = 4;
    localparam int LW = $clog2(PB + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_op = 2'd0;
    logic [23:0]   req_row = '0;
    logic [15:0]   req_col = '0;
    logic          frm_valid;
    logic          frm_done = 1'b0;
    logic [7:0]    frm_rdata = 8'h5A;
    logic [7:0]    frm_opcode;
    logic [23:0]   frm_addr;
    logic [1:0]    frm_naddr;
    logic [1:0]    frm_ndummy;
    logic [1:0]    frm_dir;
    logic [LW-1:0] frm_len;
    logic          res_valid;
    logic [2:0]    res_code;
    logic [7:0]    res_status;

    int checks = 0;
    int fails = 0;
    int res_seen = 0;
    int res_exp = 0;
    bit in_op = 1'b0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    nand_op_seq #(
        .ROW_W      (24),
        .COL_W      (16),
        .PAGE_BYTES (PB),
        .MAX_POLLS  (MP)
    ) uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_row(req_row), .req_col(req_col),
        .frm_valid(frm_valid), .frm_done(frm_done), .frm_rdata(frm_rdata),
        .frm_opcode(frm_opcode), .frm_addr(frm_addr), .frm_naddr(frm_naddr),
        .frm_ndummy(frm_ndummy), .frm_dir(frm_dir), .frm_len(frm_len),
        .res_valid(res_valid), .res_code(res_code), .res_status(res_status)
    );

    task automatic chk(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference: result code from operation and final status byte
    function automatic int model_code(int op, logic [7:0] s);
        if (s[0]) return 5;
        if (op == 0) begin
            if (s[5:4] == 2'b00) return 0;
            if (s[5:4] == 2'b01) return 1;
            return 2;
        end
        if (op == 1) return s[3] ? 3 : 0;
        return s[2] ? 4 : 0;
    endfunction

    // Every-clock monitor: outside an operation nothing may move
    always @(negedge clk) begin
        #1;
        if (!rst && !in_op && !finished) begin
            chk("R2 idle frm_valid", frm_valid, 0);
            chk("R11 idle res_valid", res_valid, 0);
            chk("R2 idle req_ready", req_ready, 1);
        end
    end

    always @(posedge clk) if (!rst && res_valid) res_seen++;

    task automatic serve(string tag, int opc, int addr, int na, int nd, int dir,
                         int len, logic [7:0] rdata, int lat);
        chk({tag, " valid"}, frm_valid, 1);
        chk({tag, " opcode"}, frm_opcode, opc);
        chk({tag, " addr"}, frm_addr, addr);
        chk({tag, " naddr"}, frm_naddr, na);
        chk({tag, " ndummy"}, frm_ndummy, nd);
        chk({tag, " dir"}, frm_dir, dir);
        chk({tag, " len"}, frm_len, len);
        chk("R2 busy req_ready", req_ready, 0);
        for (int i = 0; i < lat; i++) begin
            @(posedge clk); @(negedge clk);
            chk("R3 held valid", frm_valid, 1);
            chk("R3 held opcode", frm_opcode, opc);
            chk("R3 held addr", frm_addr, addr);
        end
        frm_done = 1'b1;
        frm_rdata = rdata;
        @(posedge clk); @(negedge clk);
        frm_done = 1'b0;
        frm_rdata = 8'h5A;
    endtask

    task automatic run_op(int op, logic [23:0] row, logic [15:0] col,
                          logic [7:0] st[$], int lat, bit noise);
        logic [7:0] last;
        int code;
        in_op = 1'b1;
        chk("R2 ready before request", req_ready, 1);
        req_valid = 1'b1; req_op = 2'(op); req_row = row; req_col = col;
        @(posedge clk); @(negedge clk);
        if (noise) begin
            req_op = 2'd2; req_row = ~row; req_col = ~col;
        end else begin
            req_valid = 1'b0;
        end
        if (op == 1) begin
            serve("R5 wren", 8'h06, 0, 0, 0, 0, 0, 8'hFF, lat);
            serve("R5 load", 8'h02, col, 2, 0, 2, PB, 8'hFF, lat);
            serve("R5 exec", 8'h10, row, 3, 0, 0, 0, 8'hFF, 0);
        end else if (op == 2) begin
            serve("R6 wren", 8'h06, 0, 0, 0, 0, 0, 8'hFF, lat);
            serve("R6 erase", 8'hD8, row, 3, 0, 0, 0, 8'hFF, 0);
        end else begin
            serve("R4 array read", 8'h13, row, 3, 0, 0, 0, 8'hFF, lat);
        end
        last = 8'h00;
        foreach (st[i]) begin
            serve("R7 poll", 8'h0F, 8'hC0, 1, 0, 1, 1, st[i], lat);
            last = st[i];
        end
        code = model_code(op, last);
        if (op == 0 && code != 5)
            serve("R4 cache read", 8'h03, col, 2, 1, 1, PB, 8'h77, lat);
        req_valid = 1'b0;
        chk("R11 res_valid", res_valid, 1);
        chk("R9 R10 R8 res_code", res_code, code);
        chk("R11 res_status", res_status, last);
        chk("R8 no frame with result", frm_valid, 0);
        res_exp++;
        @(posedge clk); @(negedge clk);
        chk("R11 pulse ends", res_valid, 0);
        chk("R2 ready after result", req_ready, 1);
        in_op = 1'b0;
    endtask

    initial begin
        #(5.0 * 200000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 reset req_ready", req_ready, 1);
        chk("R1 reset frm_valid", frm_valid, 0);
        chk("R1 reset res_valid", res_valid, 0);
        @(posedge clk); @(negedge clk);

        // R4 R9: read, ready at once, no bitflips
        run_op(0, 24'h012345, 16'h0123, '{8'h00}, 0, 0);
        // R9 corrected, after two busy polls
        run_op(0, 24'h00ABCD, 16'h0800, '{8'h01, 8'h31, 8'h10}, 2, 0);
        // R9 uncorrectable codes 10 and 11
        run_op(0, 24'h000001, 16'h0004, '{8'h20}, 1, 0);
        run_op(0, 24'h000002, 16'h0008, '{8'h30}, 0, 0);
        // R5 R10 program pass, fail, fail bit only while busy
        run_op(1, 24'h00F0F0, 16'h0010, '{8'h00}, 1, 0);
        run_op(1, 24'h00F0F1, 16'h0020, '{8'h08}, 0, 0);
        run_op(1, 24'h00F0F2, 16'h0030, '{8'h09, 8'h30}, 0, 0);
        // R6 R10 erase fail, pass, program-fail bit ignored on erase
        run_op(2, 24'h004000, 16'h0000, '{8'h04}, 0, 0);
        run_op(2, 24'h004040, 16'h0000, '{8'h00}, 1, 0);
        run_op(2, 24'h004080, 16'h0000, '{8'h01, 8'h08}, 0, 0);
        // R8 timeout: read gets no cache frame, erase too
        run_op(0, 24'h0000AA, 16'h0055, '{8'h01, 8'h01, 8'h01, 8'h01}, 0, 0);
        run_op(2, 24'h0000BB, 16'h0000, '{8'h05, 8'h05, 8'h05, 8'h05}, 1, 0);
        // R8 boundary: busy MP-1 times then ready
        run_op(1, 24'h0000CC, 16'h0066, '{8'h01, 8'h01, 8'h01, 8'h00}, 0, 0);
        // R2 requests during an operation are ignored
        run_op(1, 24'h00C0DE, 16'h0042, '{8'h01, 8'h00}, 1, 1);
        repeat (2) begin
            @(posedge clk); @(negedge clk);
            chk("R2 ignored request started nothing", frm_valid, 0);
        end
        // R2 reserved op code 3
        in_op = 1'b1;
        req_valid = 1'b1; req_op = 2'd3;
        @(posedge clk); @(negedge clk);
        chk("R2 reserved op frm_valid", frm_valid, 0);
        chk("R2 reserved op req_ready", req_ready, 1);
        req_valid = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R2 reserved op still idle", frm_valid, 0);
        in_op = 1'b0;

        @(posedge clk); @(negedge clk);
        chk("R11 result pulse count", res_seen, res_exp);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule